// File: doc/BRIEF.md
# Sticky Fault Status Bank with Self-Test Mode

This block holds a small bank of fault status registers. It sits between on-chip fault detectors and a host register port. In its normal mode a fault pulse latches a one into the matching status bit. The bit stays set until the host clears it, so no fault report is lost between two host polls. The host clears a bit by writing a zero at that position. Writing a one changes nothing, so a careless write cannot raise a false fault.

A self-test bit in the control register switches the bank into a diagnostic mode. In that mode the status bits no longer listen to the fault detectors. The host may then write any pattern, ones included, and read it back to find bits that are stuck high or stuck low. When the host drops the self-test bit, every status register returns to its default contents and the normal set and clear rules apply again. Positions that are not implemented never hold data and always read as zero.

Top module: `fault_status_bank`

## Requirements
- R1: After a synchronous active-low reset, the control register (address 0) reads 0x00 and every status register (addresses 1 to NUM_REGS) reads its default value, which is zero by default.
- R2: In normal mode a one on a fault input bit sets the matching status bit at the next clock edge, and the bit stays set after the pulse ends. Status register k takes fault_in[k*DATA_W +: DATA_W] and is read at address k+1.
- R3: In normal mode, a host write to a status register clears each bit written as zero and leaves each bit written as one unchanged.
- R4: In normal mode a host write never sets a status bit that is clear.
- R5: In normal mode, when a fault set and a host clear reach the same bit in the same cycle, the bit ends up set.
- R6: Bit 6 of the control register at address 0 is the self-test enable. Writing 1 there enters self-test mode. The other control bits always read zero.
- R7: In self-test mode the fault inputs have no effect on any status bit.
- R8: In self-test mode a host write stores its data, ones and zeros alike, in the implemented bits of the addressed status register.
- R9: A control write that clears the self-test enable while it is set returns every status register to its default value at that edge. From then on the normal rules of R2 to R5 apply again.
- R10: Bits outside the implementation mask never hold data and always read zero. The default mask gives per-register masks of 0x1F, 0x3F, 0xFF and 0x7F for status registers 0 to 3.
- R11: Reads are combinational and have no side effects. Repeated reads return the same value, and addresses above NUM_REGS read zero.
- R12: Reset clears the self-test enable and restores the status defaults, whatever the mode was before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Host write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Write address: 0 is control, k+1 is status register k |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Read data for rd_addr, combinational |
| fault_in | input | NUM_REGS*DATA_W | Fault pulses from the detectors, one bit per status bit |

## Verification
Two events can reach one status bit in the same cycle: a detector pulse that sets it, and a host write of zero that clears it. The bench provokes this by driving both on the same bit in a single cycle. It judges the outcome by reading the bit back, which must still be set.

A second same-cycle case pairs a control write that leaves self-test mode with an all-ones fault vector. Here the status registers must read their defaults afterwards, because the detectors are still cut off during that cycle.

// File: rtl/fsb_pkg.sv
// Package fsb_pkg
// Shared constants for the fault status bank. Software decodes the
// self-test enable position, so it is fixed here.
package fsb_pkg;
    localparam int unsigned ST_EN_BIT = 6;   // self-test enable in control word
    localparam int unsigned CTRL_ADDR = 0;   // control register address
endpackage

// File: rtl/fsb_ctrl.sv
// Module fsb_ctrl
// Holds the control register. Only the self-test enable is implemented.
// It raises a one-cycle restore strobe when the host clears the enable
// while it is set. Assumes DATA_W > ST_EN_BIT.
module fsb_ctrl
    import fsb_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              st_mode,
    output logic              restore,
    output logic [DATA_W-1:0] ctrl_val
);
    logic st_q;

    // Register the self-test enable; reset always clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      st_q <= 1'b0;
        else if (wr_sel) st_q <= wr_data[ST_EN_BIT];
    end

    // Leaving self-test: a write of zero while the enable is set.
    always_comb restore = wr_sel && st_q && !wr_data[ST_EN_BIT];

    // Present the control word with unimplemented bits at zero.
    always_comb begin
        ctrl_val            = '0;
        ctrl_val[ST_EN_BIT] = st_q;
    end

    assign st_mode = st_q;

    // R12
    rst_clears_st_chk: assert property (@(posedge clk) !rst_n |=> !st_mode);

    // R6
    st_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel |=> (st_mode == $past(wr_data[ST_EN_BIT])));

    // R6
    st_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(st_mode));
endmodule

// File: rtl/fsb_stat_reg.sv
// Module fsb_stat_reg
// One sticky status register. In normal mode fault pulses set bits and
// host zero-writes clear them; a set wins over a clear. In self-test mode
// faults are ignored and host writes load data. A restore strobe reloads
// the default. Bits outside MASK are held at zero.
module fsb_stat_reg #(
    parameter int unsigned      DATA_W = 8,
    parameter logic [DATA_W-1:0] MASK  = '1,
    parameter logic [DATA_W-1:0] INIT  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_mode,
    input  logic              restore,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] fault,
    output logic [DATA_W-1:0] q
);
    localparam logic [DATA_W-1:0] DFLT = INIT & MASK;

    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] nxt;

    // Bits the host asks to clear: written as zero by a selected write.
    always_comb clr_vec = wr_sel ? ~wr_data : '0;

    // Choose the next value by mode; fault set has priority over clear.
    always_comb begin
        if (st_mode) begin
            if (restore)     nxt = DFLT;
            else if (wr_sel) nxt = wr_data & MASK;
            else             nxt = q;
        end else begin
            nxt = ((q & ~clr_vec) | fault) & MASK;
        end
    end

    // State update with synchronous reset to the default.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= DFLT;
        else        q <= nxt;
    end

    // R4
    no_host_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_mode |=> ((q & ~$past(q) & ~$past(fault)) == '0));

    // R2
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_mode && !wr_sel) |=> (($past(q) & ~q) == '0));

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_mode |=> ((($past(fault) & MASK) & ~q) == '0));

    // R7
    st_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mode && !wr_sel && !restore) |=> (q == $past(q)));

    // R9
    restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_mode && restore) |=> (q == DFLT));

    // R10
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~MASK) == '0);
endmodule

// File: rtl/fsb_rd_mux.sv
// Module fsb_rd_mux
// Combinational read selection across the control word and the status
// registers. Unmapped addresses return zero. Has no state.
module fsb_rd_mux #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned ADDR_W   = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          rd_addr,
    input  logic [DATA_W-1:0]          ctrl_val,
    input  logic [NUM_REGS*DATA_W-1:0] stat_flat,
    output logic [DATA_W-1:0]          rd_data
);
    // Pick the addressed word; default zero covers unmapped addresses.
    always_comb begin
        rd_data = '0;
        if (rd_addr == '0) rd_data = ctrl_val;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (rd_addr == ADDR_W'(k + 1)) rd_data = stat_flat[k*DATA_W +: DATA_W];
        end
    end

    // R11
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr > ADDR_W'(NUM_REGS)) |-> (rd_data == '0));
endmodule

// File: rtl/fault_status_bank.sv
// Module fault_status_bank
// Top of the sticky fault status bank. Address 0 is the control register
// with the self-test enable. Addresses 1..NUM_REGS are status registers.
// Assumes single-cycle write strobes and NUM_REGS+1 fitting in ADDR_W bits.
module fault_status_bank #(
    parameter int unsigned NUM_REGS = 4,
    parameter int unsigned DATA_W   = 8,
    parameter logic [NUM_REGS*DATA_W-1:0] IMPL_MASK = 32'h7FFF_3F1F,
    parameter logic [NUM_REGS*DATA_W-1:0] STAT_INIT = '0,
    localparam int unsigned ADDR_W  = $clog2(NUM_REGS + 2),
    localparam int unsigned FLAT_W  = NUM_REGS * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [FLAT_W-1:0] fault_in
);
    import fsb_pkg::*;

    logic              ctrl_sel;
    logic              st_mode;
    logic              restore;
    logic [DATA_W-1:0] ctrl_val;
    logic [FLAT_W-1:0] stat_flat;

    // Decode a write to the control register.
    always_comb ctrl_sel = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));

    fsb_ctrl #(.DATA_W(DATA_W)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (ctrl_sel),
        .wr_data  (wr_data),
        .st_mode  (st_mode),
        .restore  (restore),
        .ctrl_val (ctrl_val)
    );

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_stat
        logic stat_sel;

        // Decode a write to status register k.
        always_comb stat_sel = wr_en && (wr_addr == ADDR_W'(k + 1));

        fsb_stat_reg #(
            .DATA_W (DATA_W),
            .MASK   (IMPL_MASK[k*DATA_W +: DATA_W]),
            .INIT   (STAT_INIT[k*DATA_W +: DATA_W])
        ) reg_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .st_mode (st_mode),
            .restore (restore),
            .wr_sel  (stat_sel),
            .wr_data (wr_data),
            .fault   (fault_in[k*DATA_W +: DATA_W]),
            .q       (stat_flat[k*DATA_W +: DATA_W])
        );
    end

    fsb_rd_mux #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .ADDR_W   (ADDR_W)
    ) rd_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (rd_addr),
        .ctrl_val  (ctrl_val),
        .stat_flat (stat_flat),
        .rd_data   (rd_data)
    );

    // R1
    rst_defaults_chk: assert property (@(posedge clk)
        !rst_n |=> (stat_flat == (STAT_INIT & IMPL_MASK)));
endmodule

// File: tb/fault_status_bank_tb.sv
// Bench for fault_status_bank: table walk, then directed reset tests.
module fault_status_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic [31:0] fault_in = '0;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fault_status_bank dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .fault_in (fault_in)
    );

    // Entry layout: we, waddr[3], wdata[8], fault[32], raddr[3], exp[8], req[4]
    localparam int NV = 20;
    localparam logic [58:0] VEC [NV] = '{
        {1'b0, 3'd0, 8'h00, 32'h0000_0005, 3'd1, 8'h05, 4'd2},  // R2 fault sets
        {1'b0, 3'd0, 8'h00, 32'h0000_0000, 3'd1, 8'h05, 4'd2},  // R2 sticky
        {1'b1, 3'd1, 8'hFE, 32'h0000_0000, 3'd1, 8'h04, 4'd3},  // R3 zero clears
        {1'b1, 3'd1, 8'hFF, 32'h0000_0000, 3'd1, 8'h04, 4'd4},  // R4 ones ignored
        {1'b0, 3'd0, 8'h00, 32'h0000_C100, 3'd2, 8'h01, 4'd10}, // R10 masked fault
        {1'b1, 3'd2, 8'h00, 32'h0000_0100, 3'd2, 8'h01, 4'd5},  // R5 set wins
        {1'b1, 3'd2, 8'h00, 32'h0000_0000, 3'd2, 8'h00, 4'd3},  // R3 clear
        {1'b1, 3'd0, 8'hFF, 32'h0000_0000, 3'd0, 8'h40, 4'd6},  // R6 enter
        {1'b0, 3'd0, 8'h00, 32'hFFFF_FFFF, 3'd3, 8'h00, 4'd7},  // R7 isolated
        {1'b0, 3'd0, 8'h00, 32'h0000_0000, 3'd1, 8'h04, 4'd7},  // R7 unchanged
        {1'b1, 3'd3, 8'hA5, 32'h0000_0000, 3'd3, 8'hA5, 4'd8},  // R8 pattern
        {1'b1, 3'd1, 8'h00, 32'h0000_0000, 3'd1, 8'h00, 4'd8},  // R8 zeros
        {1'b1, 3'd4, 8'hFF, 32'h0000_0000, 3'd4, 8'h7F, 4'd8},  // R8 ones
        {1'b1, 3'd2, 8'hFF, 32'h0000_0000, 3'd2, 8'h3F, 4'd10}, // R10 mask
        {1'b1, 3'd0, 8'h00, 32'hFFFF_FFFF, 3'd3, 8'h00, 4'd9},  // R9 restore
        {1'b0, 3'd0, 8'h00, 32'h0000_0000, 3'd2, 8'h00, 4'd9},  // R9 restore
        {1'b1, 3'd3, 8'hFF, 32'h0000_0000, 3'd3, 8'h00, 4'd9},  // R9 normal rules
        {1'b0, 3'd0, 8'h00, 32'h0080_0000, 3'd3, 8'h80, 4'd9},  // R9 faults again
        {1'b0, 3'd0, 8'h00, 32'h0000_0000, 3'd5, 8'h00, 4'd11}, // R11 unmapped
        {1'b0, 3'd0, 8'h00, 32'h0000_0000, 3'd3, 8'h80, 4'd11}  // R11 no side effect
    };

    task automatic check(input logic [7:0] exp, input string req);
        n_run++;
        if (rd_data !== exp) begin
            n_fail++;
            $display("FAIL %s addr=%0d actual=%h expected=%h", req, rd_addr, rd_data, exp);
        end
    endtask

    // One cycle of stimulus, then read rd_addr away from the edge.
    task automatic step(input logic we, input logic [2:0] wa, input logic [7:0] wd,
                        input logic [31:0] flt, input logic [2:0] ra);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd; fault_in = flt; rd_addr = ra;
        @(posedge clk);
        #2;
        wr_en = 1'b0; fault_in = '0;
        #3;
    endtask

    task automatic read_at(input logic [2:0] ra, input logic [7:0] exp, input string req);
        rd_addr = ra;
        #1;
        check(exp, req);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #2;
        // R1 reset state
        for (int a = 0; a < 5; a++) read_at(3'(a), 8'h00, "R1");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][58], VEC[i][57:55], VEC[i][54:47], VEC[i][46:15], VEC[i][14:12]);
            check(VEC[i][11:4], $sformatf("R%0d", VEC[i][3:0]));
        end

        // R12 reset inside self-test clears the enable and the pattern
        step(1'b1, 3'd0, 8'h40, 32'h0, 3'd0);
        check(8'h40, "R6");
        step(1'b1, 3'd1, 8'h15, 32'h0, 3'd1);
        check(8'h15, "R8");
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #2;
        @(negedge clk); rst_n = 1'b1;
        #2;
        read_at(3'd0, 8'h00, "R12");
        read_at(3'd1, 8'h00, "R12");
        // R12 normal rules after reset: a one write does not set
        step(1'b1, 3'd1, 8'hFF, 32'h0, 3'd1);
        check(8'h00, "R12");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule